// File: doc/BRIEF.md
# Three-Wire Mode Control Register

This block holds the configuration of a stereo audio converter's digital front end. In serial mode a host writes 8-bit words over three wires: a data line, a shift clock and a latch strobe. The leading bits of each word pick one of three register banks. The first bank holds a 7-bit attenuation code. The second holds de-emphasis, mute and double-speed controls. The third holds zero detection, word width, word-clock polarity and input format. All three pins are sampled by the block's own system clock through synchronizers, and edges are detected after the synchronizers.

When the mode-select input is low, the block is in parallel mode and the same three pins act as static levels. Two of them pick the de-emphasis rate and the third, when held low, requests double speed. Every feature that cannot be set in that mode is forced to a fixed value. Serial register contents are kept while parallel mode is active and reappear when serial mode returns. Double speed reaches the output only while the system-clock select says 384 times the sample rate.

Top module: `ctl3w_mode_regs`

## Requirements
- R1: Bits are taken on rising edges of the shift clock. The first bit received is B0. A rising edge of the latch strobe commits the word when at least 8 bits arrived since the previous strobe; the 8 most recent bits form the word.
- R2: A committed word with B0=0 loads `att_code` with B1..B7, where B1 is the most significant bit. Any other word leaves `att_code` unchanged.
- R3: A committed word with prefix B0,B1,B2 = 1,0,0 loads `deem_rate` = {B3,B4} (00 none, 01 48 kHz, 10 32 kHz, 11 44.1 kHz), `deem_on` = B5, `mute_on` = B6 and the double-speed request = B7.
- R4: A committed word with prefix 1,0,1 loads `zero_det_en` = B4, `wide20` = B5 (1 = 20-bit), `lr_swap` = B6 (1 = left channel on word clock low) and `i2s_fmt` = B7 (1 = I2S).
- R5: A committed word with prefix 1,1,x changes no output.
- R6: A strobe that follows fewer than 8 bits discards the word. Every strobe restarts the bit count. A shift-clock edge that falls in the same sampled cycle as the strobe edge is not counted.
- R7: After reset the outputs are: `att_code`=0, `deem_on`=0, `deem_rate`=11, `mute_on`=0, `dbl_speed`=0, `zero_det_en`=1, `wide20`=0, `lr_swap`=0 and `i2s_fmt`=0.
- R8: In parallel mode (`ser_mode`=0), `deem_rate` = {pin_md, pin_mc} and `deem_on` is 1 exactly when that pair is not 00. So LL gives off, HL gives 32 kHz, LH gives 48 kHz and HH gives 44.1 kHz.
- R9: In parallel mode, `pin_ml` low requests double speed. `att_code`=0, `mute_on`=0, `zero_det_en`=1, `wide20`=0, `lr_swap`=0 and `i2s_fmt`=0 are forced.
- R10: `dbl_speed` is 1 only while `sys384`=1 and double speed is requested in the active mode.
- R11: Serial traffic in parallel mode is ignored. The serial register values are restored when `ser_mode` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_mode | input | 1 | 1 = serial control, 0 = parallel static pins |
| sys384 | input | 1 | 1 when the system clock is 384x the sample rate |
| pin_md | input | 1 | Serial data, or de-emphasis select A in parallel mode |
| pin_mc | input | 1 | Shift clock, or de-emphasis select B in parallel mode |
| pin_ml | input | 1 | Latch strobe, or double-speed request (low) in parallel mode |
| att_code | output | 7 | Attenuation code |
| deem_on | output | 1 | De-emphasis enabled |
| deem_rate | output | 2 | De-emphasis rate code |
| mute_on | output | 1 | Soft mute requested |
| dbl_speed | output | 1 | Double-speed mode active |
| zero_det_en | output | 1 | Zero detection enabled |
| wide20 | output | 1 | 20-bit input words |
| lr_swap | output | 1 | Word-clock polarity swapped |
| i2s_fmt | output | 1 | I2S input format |

## Verification
The shift of a data bit and the commit of a word can fall in the same sampled cycle. The bench provokes this by sending seven bits and then raising the shift clock and the latch strobe together. The commit must win and find only seven bits, so the word is dropped and every output keeps its previous value. A following full word must then load normally, which shows that the count restarted.

// File: rtl/ctl_cfg_pkg.sv
// Shared constants and the configuration record for the three-wire
// mode control register. Assumes 8-bit control words whose field
// positions are fixed by the prefix decode.
package ctl_cfg_pkg;
    localparam int WORD_W   = 8;
    localparam int ATT_W    = WORD_W - 1;
    localparam int CNT_W    = $clog2(WORD_W + 1);
    localparam int SYNC_LEN = 2;

    // Rate codes, written as {B3,B4}
    localparam logic [1:0] RATE_NONE = 2'b00;
    localparam logic [1:0] RATE_48K  = 2'b01;
    localparam logic [1:0] RATE_32K  = 2'b10;
    localparam logic [1:0] RATE_44K  = 2'b11;

    typedef struct packed {
        logic [ATT_W-1:0] att;
        logic             deem_on;
        logic [1:0]       rate;
        logic             mute;
        logic             dsd;
        logic             zd;
        logic             wide;
        logic             swap;
        logic             i2s;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        att: '0, deem_on: 1'b0, rate: RATE_44K, mute: 1'b0, dsd: 1'b0,
        zd: 1'b1, wide: 1'b0, swap: 1'b0, i2s: 1'b0
    };
endpackage

// File: rtl/ctl_sync.sv
// Multi-stage synchronizer for asynchronous pin levels.
// Assumes each bit is an independent slow level; no bus coherency implied.
module ctl_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Purpose: move the level one flop further into the clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= '0;
            else if (g == 0) stg[g] <= d;
            else stg[g] <= stg[(g == 0) ? 0 : g - 1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/ctl_shift_rx.sv
// Serial word receiver: collects bits on shift-clock rising edges, first
// bit into position 0, and on a strobe rising edge offers the word when
// at least WORD_W bits arrived. Assumes synchronized inputs.
module ctl_shift_rx
    import ctl_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sd,
    input  logic              sck,
    input  logic              slat,
    output logic              word_vld,
    output logic [WORD_W-1:0] word
);
    logic [WORD_W-1:0] sr;
    logic [CNT_W-1:0]  cnt;
    logic              sck_d, slat_d;
    logic              sck_rise, slat_rise;

    assign sck_rise  = sck & ~sck_d;
    assign slat_rise = slat & ~slat_d;

    // Purpose: remember previous pin levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_d  <= 1'b0;
            slat_d <= 1'b0;
        end else begin
            sck_d  <= sck;
            slat_d <= slat;
        end
    end

    // Purpose: shift, count and commit; the strobe wins over a coincident bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr       <= '0;
            cnt      <= '0;
            word_vld <= 1'b0;
            word     <= '0;
        end else begin
            word_vld <= 1'b0;
            if (!enable) begin
                cnt <= '0;
            end else if (slat_rise) begin
                word_vld <= (cnt == CNT_W'(WORD_W));
                word     <= sr;
                cnt      <= '0;
            end else if (sck_rise) begin
                sr <= {sd, sr[WORD_W-1:1]};
                if (cnt != CNT_W'(WORD_W)) cnt <= cnt + 1'b1;
            end
        end
    end

    assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(WORD_W));
    assert_strobe_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && slat_rise) |=> (cnt == '0));
endmodule

// File: rtl/ctl_reg_bank.sv
// Register banks: the prefix of each committed word selects attenuation,
// mode-1 or mode-2 fields; other prefixes are dropped.
// Assumes word bit i carries Bi.
module ctl_reg_bank
    import ctl_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_vld,
    input  logic [WORD_W-1:0] word,
    output cfg_t              cfg
);
    logic             hit_att, hit_m1, hit_m2;
    logic [ATT_W-1:0] att_val;

    assign hit_att = word_vld & ~word[0];
    assign hit_m1  = word_vld &  word[0] & ~word[1] & ~word[2];
    assign hit_m2  = word_vld &  word[0] & ~word[1] &  word[2];

    // Purpose: reorder B1..B7 so that B1 becomes the code MSB.
    always_comb begin
        for (int k = 0; k < ATT_W; k++) att_val[ATT_W-1-k] = word[1+k];
    end

    // Purpose: load the addressed bank.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= CFG_RESET;
        end else begin
            if (hit_att) cfg.att <= att_val;
            if (hit_m1) begin
                cfg.rate    <= {word[3], word[4]};
                cfg.deem_on <= word[5];
                cfg.mute    <= word[6];
                cfg.dsd     <= word[7];
            end
            if (hit_m2) begin
                cfg.zd   <= word[4];
                cfg.wide <= word[5];
                cfg.swap <= word[6];
                cfg.i2s  <= word[7];
            end
        end
    end

    assert_att_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_att |=> $stable(cfg.att));
    assert_m1_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_m1 |=> $stable({cfg.rate, cfg.deem_on, cfg.mute, cfg.dsd}));
    assert_m2_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_m2 |=> $stable({cfg.zd, cfg.wide, cfg.swap, cfg.i2s}));
    assert_bad_prefix_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld && word[0] && word[1]) |=> $stable(cfg));
endmodule

// File: rtl/ctl3w_mode_regs.sv
// Top: synchronizes the three control pins, runs the serial receiver and
// register banks, and selects between serial and parallel configuration.
// Assumes ser_mode and sys384 are static or change only while idle.
module ctl3w_mode_regs
    import ctl_cfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_mode,
    input  logic             sys384,
    input  logic             pin_md,
    input  logic             pin_mc,
    input  logic             pin_ml,
    output logic [ATT_W-1:0] att_code,
    output logic             deem_on,
    output logic [1:0]       deem_rate,
    output logic             mute_on,
    output logic             dbl_speed,
    output logic             zero_det_en,
    output logic             wide20,
    output logic             lr_swap,
    output logic             i2s_fmt
);
    logic [2:0]        pins_s;
    logic              word_vld;
    logic [WORD_W-1:0] word;
    cfg_t              ser_cfg;
    cfg_t              act_cfg;

    ctl_sync #(.WIDTH(3), .STAGES(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({pin_ml, pin_mc, pin_md}), .q(pins_s)
    );

    ctl_shift_rx u_rx (
        .clk(clk), .rst_n(rst_n), .enable(ser_mode),
        .sd(pins_s[0]), .sck(pins_s[1]), .slat(pins_s[2]),
        .word_vld(word_vld), .word(word)
    );

    ctl_reg_bank u_bank (
        .clk(clk), .rst_n(rst_n),
        .word_vld(word_vld), .word(word), .cfg(ser_cfg)
    );

    // Purpose: choose serial registers or parallel static decode.
    always_comb begin
        if (ser_mode) begin
            act_cfg = ser_cfg;
        end else begin
            act_cfg         = CFG_RESET;
            act_cfg.rate    = {pins_s[0], pins_s[1]};
            act_cfg.deem_on = pins_s[0] | pins_s[1];
            act_cfg.dsd     = ~pins_s[2];
        end
    end

    assign att_code    = act_cfg.att;
    assign deem_on     = act_cfg.deem_on;
    assign deem_rate   = act_cfg.rate;
    assign mute_on     = act_cfg.mute;
    assign dbl_speed   = act_cfg.dsd & sys384;
    assign zero_det_en = act_cfg.zd;
    assign wide20      = act_cfg.wide;
    assign lr_swap     = act_cfg.swap;
    assign i2s_fmt     = act_cfg.i2s;

    assert_dsd_clock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_speed |-> sys384);
    assert_par_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_mode |-> (att_code == '0 && !mute_on && zero_det_en &&
                       !wide20 && !lr_swap && !i2s_fmt));
endmodule

// File: tb/ctl3w_mode_regs_bench.sv
// Self-checking bench: vector table of serial words, then directed tests.
module ctl3w_mode_regs_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_mode = 1'b1, sys384 = 1'b1;
    logic pin_md = 1'b0, pin_mc = 1'b0, pin_ml = 1'b0;
    logic [6:0] att_code;
    logic deem_on, mute_on, dbl_speed, zero_det_en, wide20, lr_swap, i2s_fmt;
    logic [1:0] deem_rate;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ctl3w_mode_regs u_ctl3w_mode_regs (
        .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .sys384(sys384),
        .pin_md(pin_md), .pin_mc(pin_mc), .pin_ml(pin_ml),
        .att_code(att_code), .deem_on(deem_on), .deem_rate(deem_rate),
        .mute_on(mute_on), .dbl_speed(dbl_speed), .zero_det_en(zero_det_en),
        .wide20(wide20), .lr_swap(lr_swap), .i2s_fmt(i2s_fmt)
    );

    // Observed state: {att, deem_on, rate, mute, dbl, zd, wide, swap, i2s}
    function automatic logic [15:0] obs();
        return {att_code, deem_on, deem_rate, mute_on, dbl_speed,
                zero_det_en, wide20, lr_swap, i2s_fmt};
    endfunction

    // Table: word (bit i = Bi), kind (0 att,1 mode1,2 mode2,3 bad prefix), expected state
    localparam int NV = 9;
    localparam logic [7:0]  V_WORD [NV] = '{8'b11001010, 8'b11110001, 8'b11100101,
        8'b11111011, 8'b00000111, 8'b11111110, 8'b00001001, 8'b00010101, 8'b00000000};
    localparam logic [1:0]  V_KIND [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd0, 2'd1, 2'd2, 2'd0};
    localparam logic [15:0] V_EXP  [NV] = '{
        {7'b1010011, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {7'b1010011, 1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
        {7'b1010011, 1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        {7'b1010011, 1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        {7'b1010011, 1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        {7'b1111111, 1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},
        {7'b1111111, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
        {7'b1111111, 1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        {7'b0000000, 1'b0, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}};

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Send n bits, bits[i] as the i-th bit, then a latch strobe.
    task automatic send(input logic [15:0] bits, input int n);
        for (int i = 0; i < n; i++) begin
            pin_md = bits[i];
            tick(3); pin_mc = 1'b1;
            tick(3); pin_mc = 1'b0;
        end
        tick(3); pin_ml = 1'b1;
        tick(3); pin_ml = 1'b0;
        tick(6);
    endtask

    function automatic logic [15:0] par_exp(input logic dm1, input logic dm2, input logic ds);
        return {7'b0, (dm1 | dm2), dm1, dm2, 1'b0, ds, 1'b1, 3'b000};
    endfunction

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(2);
        check("R7 reset defaults", obs(), {7'b0, 1'b0, 2'b11, 1'b0, 1'b0, 1'b1, 3'b000});

        for (int v = 0; v < NV; v++) begin
            send({8'b0, V_WORD[v]}, 8);
            case (V_KIND[v])
                2'd0:    check("R2 attenuation word", obs(), V_EXP[v]);
                2'd1:    check("R3 mode-1 word", obs(), V_EXP[v]);
                2'd2:    check("R4 mode-2 word", obs(), V_EXP[v]);
                default: check("R5 unknown prefix", obs(), V_EXP[v]);
            endcase
        end

        // R1: ten bits, the last eight form the word (mode 1, rate 11, on)
        send({6'b0, 8'b00111001, 2'b11}, 10);
        check("R1 last eight bits kept", obs(), {7'b0, 1'b1, 2'b11, 3'b001, 3'b000});

        // R6: short word discarded
        send(16'h0000, 5);
        check("R6 short word dropped", obs(), {7'b0, 1'b1, 2'b11, 3'b001, 3'b000});

        // R6: eighth shift edge coincident with strobe is not counted
        for (int i = 0; i < 7; i++) begin
            pin_md = (i != 0);
            tick(3); pin_mc = 1'b1;
            tick(3); pin_mc = 1'b0;
        end
        pin_md = 1'b1;
        tick(3); pin_mc = 1'b1; pin_ml = 1'b1;
        tick(3); pin_mc = 1'b0; pin_ml = 1'b0;
        tick(6);
        check("R6 coincident edge word dropped", obs(), {7'b0, 1'b1, 2'b11, 3'b001, 3'b000});
        send({8'b0, 8'b00000010}, 8);
        check("R6 count restarted after strobe", obs(), {7'b1000000, 1'b1, 2'b11, 3'b001, 3'b000});

        // R10: double speed gated by clock select
        send({8'b0, 8'b10111001}, 8);
        check("R10 double speed at 384", obs(), {7'b1000000, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 3'b000});
        sys384 = 1'b0; tick(1);
        check("R10 double speed blocked at 256", obs(), {7'b1000000, 1'b1, 2'b11, 1'b0, 1'b0, 1'b1, 3'b000});
        sys384 = 1'b1;

        // R8 and R9: parallel decode
        ser_mode = 1'b0;
        for (int c = 0; c < 4; c++) begin
            pin_md = c[1]; pin_mc = c[0]; pin_ml = 1'b1;
            tick(4);
            check("R8 parallel de-emphasis", obs(), par_exp(c[1], c[0], 1'b0));
        end
        pin_ml = 1'b0; tick(4);
        check("R9 parallel double speed", obs(), par_exp(1'b1, 1'b1, 1'b1));
        sys384 = 1'b0; tick(1);
        check("R10 parallel double speed blocked", obs(), par_exp(1'b1, 1'b1, 1'b0));
        sys384 = 1'b1;

        // R11: serial traffic in parallel mode ignored
        pin_md = 1'b0; pin_mc = 1'b0; pin_ml = 1'b0; tick(4);
        send({8'b0, 8'b11111110}, 8);
        send({8'b0, 8'b11100101}, 8);
        ser_mode = 1'b1; tick(2);
        check("R11 serial state kept", obs(), {7'b1000000, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 3'b000});

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule